// File: doc/BRIEF.md
# Displaced-Line Tag Tracker

This block sits beside a set-associative cache whose sets can be paired, so that a source set may push lines into a destination set. For every cache set it keeps a small record of what that set has pushed out. The record holds two shadow tags, a valid bit for each, and a saturating counter of displaced lines. The tracker follows four kinds of events:

- the start of a new pairing (commit);
- each further displacement out of the set;
- each eviction, in the destination set, of a line that had been displaced into it;
- lookups.

From these it tells the cache, for every lookup, whether the line might sit in the partner set. A secondary probe is then made only when a shadow tag matches or when the shadow list has overflowed.

One lookup can be presented per cycle. The lookup carries a set index and a tag, and its answer appears one cycle later as a valid pulse with two flags: shadow-tag hit and second-search-required. In the same cycle, commit, displacement and eviction each carry their own set index and tag, so all three can update different entries at once. The pairing choice, the data arrays and the secondary access itself belong to neighbouring logic.

Top module: `xtag_tracker`

## Requirements
- R1: After reset every entry has both shadow tags invalid and a counter of zero, so every lookup answers with xhit=0 and second=0.
- R2: A commit to set S writes its tag into slot 0 of entry S with slot 0 valid, marks slot 1 invalid, and loads the counter with 1.
- R3: A displacement to set S while a slot is free writes the tag into the lowest-numbered free slot (slot 0 before slot 1), marks it valid, and increments the counter.
- R4: A displacement to set S with both slots valid changes no tag and only increments the counter. The counter saturates at its maximum (3 for a 2-bit counter) instead of wrapping.
- R5: A lookup presented in cycle t yields res_vld=1 in cycle t+1. res_xhit=1 exactly when the lookup tag equals a valid shadow tag of that set. The answer reflects the table as it stood before any update in cycle t.
- R6: res_second=1 exactly when res_xhit=1 or the counter of the looked-up set is 3 or more.
- R7: An eviction to set S decrements its counter, which stays at 0 when it is already 0.
- R8: An eviction to set S invalidates every valid shadow tag of entry S that equals the evicted tag, and leaves the other slot unchanged.
- R9: An eviction and a displacement to the same set in the same cycle leave the counter unchanged. The invalidation is applied first, so the displacement may reuse a slot that the eviction just freed.
- R10: A commit to set S in the same cycle as a displacement or eviction to S behaves as the commit alone for entry S.
- R11: Events that name different sets in the same cycle each update only their own entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit_vld | input | 1 | New pairing committed |
| commit_set | input | SET_W | Source set of the new pairing |
| commit_tag | input | TAG_W | Tag of the first displaced line |
| disp_vld | input | 1 | Further displacement |
| disp_set | input | SET_W | Source set of the displaced line |
| disp_tag | input | TAG_W | Tag of the displaced line |
| evict_vld | input | 1 | Displaced line evicted from its destination |
| evict_set | input | SET_W | Source set that the evicted line came from |
| evict_tag | input | TAG_W | Tag of the evicted line |
| look_vld | input | 1 | Lookup request |
| look_set | input | SET_W | Set being accessed |
| look_tag | input | TAG_W | Requested tag |
| res_vld | output | 1 | Lookup answer valid, one cycle after request |
| res_xhit | output | 1 | Requested tag matched a valid shadow tag |
| res_second | output | 1 | Secondary probe of the partner set required |

## Verification
Table updates take effect at the clock edge that samples the event. A lookup presented in the same cycle still sees the older table. Its answer is registered once and so is due exactly one edge after the request. The bench drives each cycle's stimulus on the falling edge. It computes the expected answer from its own model as that model stood before the cycle's updates, then applies the updates to the model, and compares res_vld, res_xhit and res_second on the next falling edge, a full edge after the request. Directed sequences cover saturation, underflow and same-cycle collisions, and a long pseudo-random sweep over a small tag and set range follows them.

// File: rtl/xtt_pkg.sv
package xtt_pkg;
  // number of shadow slots kept per set entry
  localparam int XT_SLOTS = 2;
  // counter value at or above which a second search is forced
  localparam int XT_OVF_LEVEL = 3;
endpackage

// File: rtl/xtt_entry.sv
module xtt_entry
  import xtt_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_commit,
  input  logic             do_disp,
  input  logic             do_evict,
  input  logic [TAG_W-1:0] commit_tag,
  input  logic [TAG_W-1:0] disp_tag,
  input  logic [TAG_W-1:0] evict_tag,
  output logic [TAG_W-1:0] tag_q [XT_SLOTS],
  output logic [XT_SLOTS-1:0] vld_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [TAG_W-1:0]    tag_n [XT_SLOTS];
  logic [XT_SLOTS-1:0] vld_n;
  logic [CNT_W-1:0]    cnt_n;
  logic                placed;

  always_comb begin
    tag_n  = tag_q;
    vld_n  = vld_q;
    cnt_n  = cnt_q;
    placed = 1'b0;
    if (do_commit) begin
      tag_n[0] = commit_tag;
      vld_n    = XT_SLOTS'(1);
      cnt_n    = CNT_ONE;
    end else begin
      if (do_evict) begin
        for (int i = 0; i < XT_SLOTS; i++)
          if (vld_q[i] && tag_q[i] == evict_tag) vld_n[i] = 1'b0;
      end
      if (do_disp) begin
        for (int i = 0; i < XT_SLOTS; i++) begin
          if (!placed && !vld_n[i]) begin
            tag_n[i] = disp_tag;
            vld_n[i] = 1'b1;
            placed   = 1'b1;
          end
        end
      end
      if (do_disp && !do_evict && cnt_q != CNT_MAX) cnt_n = cnt_q + CNT_ONE;
      else if (do_evict && !do_disp && cnt_q != '0) cnt_n = cnt_q - CNT_ONE;
    end
  end

  // tag storage has no reset so it can map onto plain memory
  always_ff @(posedge clk) tag_q <= tag_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_n;
      cnt_q <= cnt_n;
    end
  end

  // R2
  commit_load_chk: assert property (@(posedge clk) disable iff (rst)
    do_commit |=> (cnt_q == CNT_ONE && vld_q == XT_SLOTS'(1)));
  // R3
  disp_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (do_disp && !do_commit && !do_evict && cnt_q != CNT_MAX)
      |=> cnt_q == $past(cnt_q) + CNT_ONE);
  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (do_disp && !do_commit && !do_evict && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R7
  evict_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (do_evict && !do_commit && !do_disp && cnt_q == '0) |=> cnt_q == '0);
  // R9
  pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (do_evict && do_disp && !do_commit) |=> $stable(cnt_q));
endmodule

// File: rtl/xtt_lookup.sv
module xtt_lookup
  import xtt_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int CNT_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                look_vld,
  input  logic [TAG_W-1:0]    look_tag,
  input  logic [TAG_W-1:0]    sel_tag [XT_SLOTS],
  input  logic [XT_SLOTS-1:0] sel_vld,
  input  logic [CNT_W-1:0]    sel_cnt,
  output logic                res_vld,
  output logic                res_xhit,
  output logic                res_second
);
  logic [XT_SLOTS-1:0] match;
  logic                ovf;

  generate
    for (genvar i = 0; i < XT_SLOTS; i++) begin : g_cmp
      assign match[i] = sel_vld[i] && (sel_tag[i] == look_tag);
    end
  endgenerate

  assign ovf = (32'(sel_cnt) >= XT_OVF_LEVEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld    <= 1'b0;
      res_xhit   <= 1'b0;
      res_second <= 1'b0;
    end else begin
      res_vld    <= look_vld;
      res_xhit   <= look_vld && (|match);
      res_second <= look_vld && ((|match) || ovf);
    end
  end

  // R5
  res_timing_chk: assert property (@(posedge clk) disable iff (rst)
    look_vld |=> res_vld);
  // R5
  res_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !look_vld |=> !res_vld && !res_xhit && !res_second);
  // R6
  hit_forces_second_chk: assert property (@(posedge clk) disable iff (rst)
    res_xhit |-> res_second);
endmodule

// File: rtl/xtag_tracker.sv
module xtag_tracker
  import xtt_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int TAG_W = 8,
  parameter int CNT_W = 2,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_vld,
  input  logic [SET_W-1:0] commit_set,
  input  logic [TAG_W-1:0] commit_tag,
  input  logic             disp_vld,
  input  logic [SET_W-1:0] disp_set,
  input  logic [TAG_W-1:0] disp_tag,
  input  logic             evict_vld,
  input  logic [SET_W-1:0] evict_set,
  input  logic [TAG_W-1:0] evict_tag,
  input  logic             look_vld,
  input  logic [SET_W-1:0] look_set,
  input  logic [TAG_W-1:0] look_tag,
  output logic             res_vld,
  output logic             res_xhit,
  output logic             res_second
);
  logic [TAG_W-1:0]    e_tag [SETS][XT_SLOTS];
  logic [XT_SLOTS-1:0] e_vld [SETS];
  logic [CNT_W-1:0]    e_cnt [SETS];

  generate
    for (genvar s = 0; s < SETS; s++) begin : g_set
      xtt_entry #(.TAG_W(TAG_W), .CNT_W(CNT_W)) i_entry (
        .clk       (clk),
        .rst       (rst),
        .do_commit (commit_vld && commit_set == SET_W'(s)),
        .do_disp   (disp_vld   && disp_set   == SET_W'(s)),
        .do_evict  (evict_vld  && evict_set  == SET_W'(s)),
        .commit_tag(commit_tag),
        .disp_tag  (disp_tag),
        .evict_tag (evict_tag),
        .tag_q     (e_tag[s]),
        .vld_q     (e_vld[s]),
        .cnt_q     (e_cnt[s])
      );
    end
  endgenerate

  xtt_lookup #(.TAG_W(TAG_W), .CNT_W(CNT_W)) i_lookup (
    .clk       (clk),
    .rst       (rst),
    .look_vld  (look_vld),
    .look_tag  (look_tag),
    .sel_tag   (e_tag[look_set]),
    .sel_vld   (e_vld[look_set]),
    .sel_cnt   (e_cnt[look_set]),
    .res_vld   (res_vld),
    .res_xhit  (res_xhit),
    .res_second(res_second)
  );
endmodule

// File: tb/test_xtag_tracker.sv
module test_xtag_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 8;
  localparam int TAG_W = 8;
  localparam int CNT_W = 2;
  localparam int SET_W = 3;
  localparam int CMAX = 3;

  logic clk = 0, rst = 1;
  logic commit_vld = 0, disp_vld = 0, evict_vld = 0, look_vld = 0;
  logic [SET_W-1:0] commit_set = 0, disp_set = 0, evict_set = 0, look_set = 0;
  logic [TAG_W-1:0] commit_tag = 0, disp_tag = 0, evict_tag = 0, look_tag = 0;
  logic res_vld, res_xhit, res_second;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  int m_tag [SETS][2];
  bit m_vld [SETS][2];
  int m_cnt [SETS];

  always #(CLK_PERIOD/2) clk = ~clk;

  xtag_tracker #(.SETS(SETS), .TAG_W(TAG_W), .CNT_W(CNT_W)) i_xtag_tracker (
    .clk(clk), .rst(rst),
    .commit_vld(commit_vld), .commit_set(commit_set), .commit_tag(commit_tag),
    .disp_vld(disp_vld), .disp_set(disp_set), .disp_tag(disp_tag),
    .evict_vld(evict_vld), .evict_set(evict_set), .evict_tag(evict_tag),
    .look_vld(look_vld), .look_set(look_set), .look_tag(look_tag),
    .res_vld(res_vld), .res_xhit(res_xhit), .res_second(res_second));

  task automatic model_apply(bit cv, int cs, int ct, bit dv, int ds, int dt,
                             bit ev, int es, int et);
    for (int s = 0; s < SETS; s++) begin
      bit c = cv && cs == s, d = dv && ds == s, e = ev && es == s;
      if (c) begin                       // R2, R10
        m_tag[s][0] = ct; m_vld[s][0] = 1; m_vld[s][1] = 0; m_cnt[s] = 1;
      end else begin
        if (e) for (int k = 0; k < 2; k++)              // R8
          if (m_vld[s][k] && m_tag[s][k] == et) m_vld[s][k] = 0;
        if (d) begin                                     // R3, R4
          if (!m_vld[s][0]) begin m_tag[s][0] = dt; m_vld[s][0] = 1; end
          else if (!m_vld[s][1]) begin m_tag[s][1] = dt; m_vld[s][1] = 1; end
        end
        if (d && !e) m_cnt[s] = (m_cnt[s] < CMAX) ? m_cnt[s] + 1 : CMAX;   // R4
        else if (e && !d) m_cnt[s] = (m_cnt[s] > 0) ? m_cnt[s] - 1 : 0;    // R7, R9
      end
    end
  endtask

  // one cycle: drive on falling edge, check lookup answer on the next falling edge
  task automatic step(string lbl, bit cv, int cs, int ct, bit dv, int ds, int dt,
                      bit ev, int es, int et, bit lv, int ls, int lt);
    bit ex_hit, ex_sec;
    commit_vld = cv; commit_set = SET_W'(cs); commit_tag = TAG_W'(ct);
    disp_vld = dv;   disp_set = SET_W'(ds);   disp_tag = TAG_W'(dt);
    evict_vld = ev;  evict_set = SET_W'(es);  evict_tag = TAG_W'(et);
    look_vld = lv;   look_set = SET_W'(ls);   look_tag = TAG_W'(lt);
    ex_hit = lv && ((m_vld[ls][0] && m_tag[ls][0] == lt) || (m_vld[ls][1] && m_tag[ls][1] == lt));
    ex_sec = lv && (ex_hit || m_cnt[ls] >= 3);
    model_apply(cv, cs, ct, dv, ds, dt, ev, es, et);
    @(posedge clk);
    @(negedge clk);
    commit_vld = 0; disp_vld = 0; evict_vld = 0; look_vld = 0;
    n_tests++;
    if (res_vld !== lv || res_xhit !== ex_hit || res_second !== ex_sec) begin
      n_fail++;
      $display("FAIL %s: vld/xhit/second=%0b%0b%0b expected %0b%0b%0b",
               lbl, res_vld, res_xhit, res_second, lv, ex_hit, ex_sec);
    end
  endtask

  task automatic look(string lbl, int ls, int lt);
    step(lbl, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, ls, lt);
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) begin
      m_cnt[s] = 0; m_vld[s][0] = 0; m_vld[s][1] = 0; m_tag[s][0] = 0; m_tag[s][1] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state on every set
    for (int s = 0; s < SETS; s++) look("R1 reset", s, 0);
    // R2: commit
    step("R2 commit", 1, 2, 'h11, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    look("R2 slot0 hit", 2, 'h11);
    look("R2 count1 miss", 2, 'h22);
    // R3: fill free slot
    step("R3 disp", 0, 0, 0, 1, 2, 'h22, 0, 0, 0, 0, 0, 0);
    look("R3 slot1 hit", 2, 'h22);
    // R4: full list, overflow then saturation
    step("R4 disp full", 0, 0, 0, 1, 2, 'h33, 0, 0, 0, 0, 0, 0);
    look("R6 count3 forces second", 2, 'h33);
    look("R4 tag not stored", 2, 'h33);
    step("R4 disp sat", 0, 0, 0, 1, 2, 'h55, 0, 0, 0, 0, 0, 0);
    look("R4 saturates not wraps", 2, 'h44);
    step("R7 evict", 0, 0, 0, 0, 0, 0, 1, 2, 'h33, 0, 0, 0);
    look("R7 count down to 2", 2, 'h44);
    // R8: invalidate matching tag only
    step("R8 evict", 0, 0, 0, 0, 0, 0, 1, 2, 'h11, 0, 0, 0);
    look("R8 evicted gone", 2, 'h11);
    look("R8 other kept", 2, 'h22);
    // R9: evict + disp same set
    step("R9 pair", 0, 0, 0, 1, 2, 'h66, 1, 2, 'h22, 0, 0, 0);
    look("R9 old gone", 2, 'h22);
    look("R9 new stored", 2, 'h66);
    step("R9 disp", 0, 0, 0, 1, 2, 'h77, 0, 0, 0, 0, 0, 0);
    look("R9 count held", 2, 'h99);
    // R7: floor at zero
    for (int i = 0; i < 5; i++) step("R7 drain", 0, 0, 0, 0, 0, 0, 1, 2, 'hF0, 0, 0, 0);
    look("R7 no underflow", 2, 'hF1);
    // R10: commit overrides same-set disp/evict
    step("R10 commit+disp", 1, 2, 'h88, 1, 2, 'h99, 1, 2, 'h66, 0, 0, 0);
    look("R10 disp dropped", 2, 'h99);
    look("R10 commit kept", 2, 'h88);
    // R5: lookup sees table before same-cycle update
    step("R5 same-cycle", 1, 5, 'hAA, 0, 0, 0, 0, 0, 0, 1, 5, 'hAA);
    look("R5 next cycle", 5, 'hAA);
    // R11: different sets in one cycle
    step("R11 multi", 1, 1, 'h01, 1, 5, 'h02, 1, 2, 'h88, 1, 1, 'h01);
    look("R11 set1", 1, 'h01);
    look("R11 set5", 5, 'h02);
    look("R11 set2", 2, 'h88);
    // pseudo-random sweep, R5 R6 and all updates against model
    begin
      logic [31:0] lf = 32'hACE1_2345;
      for (int i = 0; i < 4000; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        step("R5/R6 sweep", lf[0] & lf[1] & lf[2], int'(lf[4:3]), 'h10 + int'(lf[6:5]),
             lf[7], int'(lf[9:8]), 'h10 + int'(lf[11:10]),
             lf[12], int'(lf[14:13]), 'h10 + int'(lf[16:15]),
             lf[17] | lf[18], int'(lf[20:19]), 'h10 + int'(lf[22:21]));
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule